// File: doc/BRIEF.md
# Prescaled Timer Counter with Compare Reset

This block is a 16-bit up counter that advances on pulses from a binary prescaler. Software picks a divide ratio of one to 128 and can enable an interrupt request on counter overflow. It can also turn on a modulus mode. In that mode a match between the count and a compare value sends the count back to zero, so the counter repeats a period set by the compare value. The counter only runs while a global run input is high. Dropping that input freezes the count and clears the prescaler chain.

A new divide ratio does not apply at once. It is held as a request and only becomes active in a cycle where every stage of the prescaler chain reads zero. This keeps ratio changes free of partial periods. The overflow flag is set only by a natural wrap from the maximum count to zero. A wrap forced by a compare reset from the maximum count does not set it. Software clears the flag by writing a one. A one-cycle strobe marks each compare match.

Top module: `modtick_timer`

## Requirements
- R1: After reset, count, overflow flag, interrupt request, match strobe, control readback and compare readback are all zero.
- R2: The control word is {irq_en[4], rst_en[3], psel[2:0]}. While the run input is high, the count advances by one on each prescaler tick. The active select s gives one tick every 2^s clock cycles: 000 gives 1 and 111 gives 128.
- R3: A written psel becomes the active select only on a clock edge where the prescaler chain is all zero. Until then, ticks keep the previous ratio.
- R4: While the run input is low, the count holds its value and the prescaler chain is cleared. The first tick after the run input goes high again comes 2^s cycles later.
- R5: With rst_en at 0, a tick at count 0xFFFF wraps the count to 0x0000 and sets the overflow flag in the same edge.
- R6: With rst_en at 1, a tick at which the count equals the compare value loads 0x0000 instead of incrementing.
- R7: With rst_en at 1 and a compare value of 0x0000, the count stays at 0x0000 on every tick.
- R8: With rst_en at 1 and a compare value of 0xFFFF, the reset from 0xFFFF to 0x0000 does not set the overflow flag.
- R9: A tick at which the count equals the compare value raises the match strobe for exactly the following clock cycle, whatever the value of rst_en.
- R10: A one on the clear input clears the overflow flag on the next edge. A flag set in that same edge wins over the clear.
- R11: The interrupt request is high exactly when the overflow flag is set and irq_en is 1.
- R12: A control write or compare write takes effect on the next edge, and the written value appears on the readback outputs from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Global run input; low freezes the count and clears the prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word {irq_en, rst_en, psel[2:0]} |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ctrl_rdata | output | 5 | Control word readback |
| cmp_rdata | output | 16 | Compare value readback |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |
| match_pulse | output | 1 | One-cycle compare match strobe |

## Verification
The assertions check several relations on every cycle. The count only steps by one or goes to zero, and it holds while the run input is low. A match strobe always follows a cycle where the count equalled the compare value. In modulus mode a strobe coincides with a zero count. A rising overflow flag always comes from the maximum count with no compare reset at that value, and the interrupt never rises without the flag. The bench scenarios are needed for the timing rules. These include the divide ratio per select value and the delay of a new select until the chain reaches zero. They also cover the full 65536-count passes that show a natural wrap raising the flag while a compare reset at the maximum count does not.

// File: rtl/mt_pkg.sv
package mt_pkg;

   localparam int SEL_W  = 3;
   localparam int STAGES = (1 << SEL_W) - 1;

   typedef struct packed {
      logic             irq_en;
      logic             rst_en;
      logic [SEL_W-1:0] psel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
   parameter int SEL_W     = 3,
   parameter bit SYNC_LOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel_req,
   output logic [SEL_W-1:0] sel_act,
   output logic             tick
);

   localparam int STAGES = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel_w
      $error("mt_prescaler: SEL_W must lie in 1..5");
   end

   logic [STAGES-1:0] chain_q;
   logic [STAGES:0]   ones;
   logic              chain_zero;

   // ones[k] is high when the lowest k stages of the chain all read one
   assign ones[0] = 1'b1;
   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign ones[k+1] = ones[k] & chain_q[k];
   end

   assign chain_zero = (chain_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (!run) begin
         chain_q <= '0;
      end else begin
         chain_q <= chain_q + 1'b1;
      end
   end

   if (SYNC_LOAD) begin : g_sync_load
      logic [SEL_W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= '0;
         end else if (chain_zero) begin
            act_q <= sel_req;
         end
      end
      assign sel_act = act_q;
   end else begin : g_direct_load
      assign sel_act = sel_req;
   end

   assign tick = run & ones[sel_act];

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rst_en,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] count,
   output logic             match_pulse,
   output logic             wrap_evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("mt_counter: CNT_W must lie in 2..32");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             hit;
   logic             cmp_load;

   assign hit      = (cnt_q == cmp_val);
   assign cmp_load = tick & rst_en & hit;
   assign wrap_evt = tick & ~cmp_load & (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cmp_load) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
      end else begin
         match_pulse <= tick & hit;
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/mt_status.sv
module mt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   input  logic irq_en,
   output logic flag,
   output logic irq
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_evt) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign irq  = flag_q & irq_en;

endmodule

// File: rtl/modtick_timer.sv
module modtick_timer
   import mt_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter bit SYNC_LOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_en,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              cmp_we,
   input  logic [CNT_W-1:0]  cmp_wdata,
   input  logic              ovf_clr,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic [CNT_W-1:0]  cmp_rdata,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic              irq,
   output logic              match_pulse
);

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic             ctrl_rst_en;
   logic             ctrl_irq_en;
   logic [SEL_W-1:0] sel_act;
   logic             tick;
   logic             wrap_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_t'(ctrl_wdata);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_we) begin
         cmp_q <= cmp_wdata;
      end
   end

   assign ctrl_rst_en = ctrl_q.rst_en;
   assign ctrl_irq_en = ctrl_q.irq_en;

   mt_prescaler #(
      .SEL_W     (SEL_W),
      .SYNC_LOAD (SYNC_LOAD)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_en),
      .sel_req (ctrl_q.psel),
      .sel_act (sel_act),
      .tick    (tick)
   );

   mt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .rst_en      (ctrl_rst_en),
      .cmp_val     (cmp_q),
      .count       (count),
      .match_pulse (match_pulse),
      .wrap_evt    (wrap_evt)
   );

   mt_status u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (wrap_evt),
      .clr_req (ovf_clr),
      .irq_en  (ctrl_irq_en),
      .flag    (ovf_flag),
      .irq     (irq)
   );

   assign ctrl_rdata = ctrl_q;
   assign cmp_rdata  = cmp_q;

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmr_en,
   input logic             rst_en,
   input logic             irq_en,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             irq,
   input logic             match_pulse,
   input logic             ovf_clr
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));

   // R4
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tmr_en) |-> (count == $past(count)));

   // R6
   cmp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && $past(rst_en)) |-> (count == '0));

   // R8
   ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (($past(count) == CNT_MAX) && !($past(rst_en) && ($past(cmp) == CNT_MAX))));

   // R9
   match_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> ($past(count) == $past(cmp)));

   // R10
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf_clr) && ovf_flag) |-> ($past(count) == CNT_MAX));

   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_flag && irq_en));

endmodule

bind modtick_timer mt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmr_en      (tmr_en),
   .rst_en      (ctrl_rst_en),
   .irq_en      (ctrl_irq_en),
   .cmp         (cmp_q),
   .count       (count),
   .ovf_flag    (ovf_flag),
   .irq         (irq),
   .match_pulse (match_pulse),
   .ovf_clr     (ovf_clr)
);

// File: tb/test_modtick_timer.sv
module test_modtick_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_en = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [4:0]  ctrl_wdata = '0;
   logic        cmp_we = 1'b0;
   logic [15:0] cmp_wdata = '0;
   logic        ovf_clr = 1'b0;
   logic [4:0]  ctrl_rdata;
   logic [15:0] cmp_rdata;
   logic [15:0] count;
   logic        ovf_flag;
   logic        irq;
   logic        match_pulse;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   // reference state
   logic [6:0]  m_pre;
   logic [2:0]  m_act, m_pend;
   logic [15:0] m_cnt, m_cmp;
   logic        m_ovf, m_match, m_rsten, m_irqen;

   modtick_timer i_modtick_timer (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr),
      .ctrl_rdata(ctrl_rdata), .cmp_rdata(cmp_rdata), .count(count),
      .ovf_flag(ovf_flag), .irq(irq), .match_pulse(match_pulse)
   );

   always #2.5 clk = ~clk;

   function automatic logic [6:0] sel_mask(input logic [2:0] s);
      return 7'((8'd1 << s) - 8'd1);
   endfunction

   function automatic bit exp_tick(input logic run, input logic [6:0] pre, input logic [2:0] s);
      return run && ((pre & sel_mask(s)) == sel_mask(s));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = '0; m_act = '0; m_pend = '0; m_cnt = '0; m_cmp = '0;
         m_ovf = 1'b0; m_match = 1'b0; m_rsten = 1'b0; m_irqen = 1'b0;
      end else begin
         bit t, hit, set;
         logic [15:0] n_cnt;
         t     = exp_tick(tmr_en, m_pre, m_act);
         hit   = (m_cnt == m_cmp);
         set   = 1'b0;
         n_cnt = m_cnt;
         if (t) begin
            if (m_rsten && hit) n_cnt = '0;
            else begin
               if (m_cnt == 16'hFFFF) set = 1'b1;
               n_cnt = m_cnt + 16'd1;
            end
         end
         m_ovf   = set ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
         m_match = t && hit;
         if (m_pre == '0) m_act = m_pend;
         m_pre = tmr_en ? m_pre + 7'd1 : 7'd0;
         m_cnt = n_cnt;
         if (ctrl_we) {m_irqen, m_rsten, m_pend} = ctrl_wdata;
         if (cmp_we) m_cmp = cmp_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && chk_on && !done) begin
         check(count == m_cnt, "R2", "count", 32'(count), 32'(m_cnt));
         check(ovf_flag == m_ovf, "R5", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
         check(irq == (m_ovf & m_irqen), "R11", "irq", 32'(irq), 32'(m_ovf & m_irqen));
         check(match_pulse == m_match, "R9", "match_pulse", 32'(match_pulse), 32'(m_match));
         check(ctrl_rdata == {m_irqen, m_rsten, m_pend}, "R12", "ctrl_rdata",
               32'(ctrl_rdata), 32'({m_irqen, m_rsten, m_pend}));
         check(cmp_rdata == m_cmp, "R12", "cmp_rdata", 32'(cmp_rdata), 32'(m_cmp));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic irq_e, input logic rst_e, input logic [2:0] ps);
      ctrl_wdata = {irq_e, rst_e, ps};
      ctrl_we = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wr_cmp(input logic [15:0] v);
      cmp_wdata = v;
      cmp_we = 1'b1;
      @(negedge clk);
      cmp_we = 1'b0;
   endtask

   task automatic pulse_clr();
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
   endtask

   initial begin
      logic [15:0] keep;
      bit ok, seen;
      void'($urandom(32'd20240611));
      wait_cyc(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(count == 16'h0 && !ovf_flag && !irq && !match_pulse && ctrl_rdata == 5'h0
            && cmp_rdata == 16'h0, "R1", "reset state",
            32'({count, ovf_flag, irq, match_pulse}), 32'h0);
      chk_on = 1'b1;

      // R7: modulus mode with compare 0 holds the count at zero
      wr_ctrl(1'b0, 1'b1, 3'd0);
      tmr_en = 1'b1;
      ok = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (count != 16'h0) ok = 1'b0;
      end
      check(ok, "R7", "count held at zero", 32'(count), 32'h0);

      // R6 / R9: compare 5 gives a 0..5 cycle with a strobe on return
      wr_cmp(16'd5);
      seen = 1'b0;
      for (int i = 0; i < 20 && !seen; i++) begin
         if (count == 16'd5) seen = 1'b1;
         else @(negedge clk);
      end
      check(seen, "R6", "count reaches compare", 32'(count), 32'd5);
      @(negedge clk);
      check(count == 16'h0, "R6", "reset after compare", 32'(count), 32'h0);
      check(match_pulse == 1'b1, "R9", "match strobe high", 32'(match_pulse), 32'h1);
      @(negedge clk);
      check(match_pulse == 1'b0 && count == 16'd1, "R9", "strobe one cycle",
            32'({match_pulse, count}), 32'h1);

      // R8: compare 0xFFFF in modulus mode, no overflow on the forced wrap
      wr_cmp(16'hFFFF);
      seen = 1'b0;
      for (int i = 0; i < 65560; i++) begin
         @(negedge clk);
         if (count == 16'hFFFF) seen = 1'b1;
      end
      check(seen && ovf_flag == 1'b0 && count < 16'd40, "R8", "no flag on compare wrap",
            32'({seen, ovf_flag}), 32'h2);

      // R5: free-running wrap sets the flag
      wr_ctrl(1'b0, 1'b0, 3'd0);
      seen = 1'b0;
      for (int i = 0; i < 65600 && !seen; i++) begin
         if (count == 16'hFFFF) seen = 1'b1;
         else @(negedge clk);
      end
      @(negedge clk);
      check(seen && count == 16'h0 && ovf_flag, "R5", "natural wrap",
            32'({ovf_flag, count}), 32'h10000);

      // R11: enable raises the request, then R10 clear drops both
      wr_ctrl(1'b1, 1'b0, 3'd0);
      check(irq == 1'b1, "R11", "irq with flag", 32'(irq), 32'h1);
      pulse_clr();
      check(ovf_flag == 1'b0 && irq == 1'b0, "R10", "flag cleared",
            32'({ovf_flag, irq}), 32'h0);

      // R3: a new select waits for the chain to reach zero
      wr_ctrl(1'b0, 1'b0, 3'd7);
      wait_cyc(300);
      keep = count;
      for (int i = 0; i < 400 && count == keep; i++) @(negedge clk);
      wr_ctrl(1'b0, 1'b0, 3'd0);
      keep = count;
      ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (count != keep) ok = 1'b0;
      end
      check(ok, "R3", "old ratio kept until chain zero", 32'(count), 32'(keep));
      wait_cyc(40);

      // R4: run input low freezes the count
      wr_ctrl(1'b0, 1'b0, 3'd2);
      wait_cyc(10);
      tmr_en = 1'b0;
      @(negedge clk);
      keep = count;
      ok = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (count != keep) ok = 1'b0;
      end
      check(ok, "R4", "count frozen while stopped", 32'(count), 32'(keep));
      tmr_en = 1'b1;
      wait_cyc(3);
      check(count == keep, "R4", "no tick before 2^s cycles", 32'(count), 32'(keep));
      @(negedge clk);
      check(count == keep + 16'd1, "R4", "first tick after restart", 32'(count), 32'(keep + 16'd1));

      // R2 / R6 / R9 / R10 / R12: random stimulus against the reference
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = int'($urandom_range(0, 999));
         if (r < 12) begin
            ctrl_wdata = 5'($urandom);
            ctrl_we = 1'b1;
         end else if (r < 20) begin
            cmp_wdata = 16'($urandom_range(0, 200));
            cmp_we = 1'b1;
         end else if (r < 40) begin
            ovf_clr = 1'b1;
         end else if (r < 45) begin
            tmr_en = ~tmr_en;
         end
         @(negedge clk);
         ctrl_we = 1'b0;
         cmp_we = 1'b0;
         ovf_clr = 1'b0;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule